// File: doc/BRIEF.md
# Half-Period-Gated Island Port to a Synchronous Master

This block joins a locally clocked island to an external synchronous master. Only the island side synchronizes. The master starts a transfer by raising `extEnable`. A hold gate passes that level on to the island as the request `islandReq`. When the island has enabled the port and the request is present, the port controller asks the island clock generator to stop the clock (`pauseReq`). It waits until the generator confirms the pause (`pauseGrant`), and then raises `islandAck`. At that moment data may cross: the master's output registers were already stable before it raised `extEnable`, so no data latches are used.

Two hold gates sit on the master side. Each passes one edge direction only while the master clock is in the first half of its period, and otherwise keeps its value. The first gate passes a rising acknowledge to the master as `extDone`. The second passes a falling enable to the island as a falling request. Because of this gating, the master can sample `extDone` on its own rising edge with no synchronizer. The island clock stays paused until the request has fallen. After the request falls, the port waits until the clock generator confirms the release before it will accept a new request. The master clock must run slower than the island clock, so that the island side completes its handshake within one master period.

The model runs on a free-running reference clock `clk`. In this model, `extClk` is a level sampled on that clock.

Top module: `sync_edge_port`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `islandReq`, `islandAck`, `pauseReq` and `extDone` are all 0.
- R2: If `extEnable` is 1 at a `clk` rising edge, `islandReq` is 1 after that edge, whatever the phase of `extClk`.
- R3: `pauseReq` rises only after an edge at which both `portEnable` and `islandReq` were 1. With `portEnable` held at 0, a raised `extEnable` leaves `pauseReq` and `extDone` at 0.
- R4: `islandAck` rises only after an edge at which `pauseReq` and `pauseGrant` were both 1.
- R5: `extDone` rises only after an edge at which `islandAck` was 1 and `extClk` was 1 (1 marks the first half-period). If `islandAck` is 1 while `extClk` is 0, `extDone` waits for the high half. A rising `extDone` completes exactly one raised `extEnable`, in order.
- R6: `islandReq` falls only after an edge at which `extEnable` was 0 and `extClk` was 1. An `extEnable` that falls while `extClk` is 0 is held high at `islandReq` until the high half.
- R7: While `pauseReq` and `islandReq` are both 1, `pauseReq` stays 1. Once `islandReq` is 0 while `islandAck` is 1, both `pauseReq` and `islandAck` drop at the next edge.
- R8: `extDone` is 0 after any edge at which `islandAck` was 0.
- R9: After a release, `pauseReq` does not rise again while `pauseGrant` is still 1, even if a new request and `portEnable` are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock of the model |
| rstN | input | 1 | Asynchronous active-low reset |
| extClk | input | 1 | Master clock level; 1 is the first half-period |
| extEnable | input | 1 | Master's transfer request |
| extDone | output | 1 | Gated acknowledge returned to the master |
| portEnable | input | 1 | Island logic allows the port to run |
| islandReq | output | 1 | Gated request seen by the island |
| islandAck | output | 1 | Port acknowledge; transfer window open |
| pauseReq | output | 1 | Request to stop the island clock |
| pauseGrant | input | 1 | Clock generator: 1 = clock stopped |

## Verification
The hardest situations to reach from the ports are three timing overlaps. The first is an acknowledge that appears during the low half of the master period. The second is an enable that falls during the low half. The third is a new request that arrives while the clock generator is still reporting a paused clock from the previous transfer.

The bench models the clock generator with adjustable pause and release latencies, and sweeps the pause latency so that the acknowledge lands in both halves. It adds a master mode that drops the enable on the falling master edge, and it runs a burst of transfers with a long release latency. Dedicated flags confirm that each of these situations actually occurred.

// File: rtl/port_pkg.sv
package port_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PAUSE   = 2'd1,
    ST_XFER    = 2'd2,
    ST_RELEASE = 2'd3
  } portState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pauseReq;
    logic ackLevel;
  } portStrobes_t;

endpackage

// File: rtl/phase_hold_gate.sv
// Hold element: one edge direction passes freely, the other passes only
// while phaseOk is 1; otherwise the output keeps its value.
module phase_hold_gate #(
  parameter bit GATE_RISE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic phaseOk,
  input  logic din,
  output logic dout
);
  logic q, qNext;

  generate
    if (GATE_RISE) begin : g_rise
      always_comb begin
        if (!din)         qNext = 1'b0;
        else if (phaseOk) qNext = 1'b1;
        else              qNext = q;
      end
    end else begin : g_fall
      always_comb begin
        if (din)          qNext = 1'b1;
        else if (phaseOk) qNext = 1'b0;
        else              qNext = q;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= 1'b0;
    else       q <= qNext;
  end

  assign dout = q;
endmodule

// File: rtl/port_datapath.sv
module port_datapath
  import port_pkg::*;
#(
  parameter bit FIRST_HALF_LEVEL = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         extClk,
  input  logic         extEnable,
  input  portStrobes_t strobes,
  output logic         reqGated,
  output logic         doneGated
);
  logic inFirstHalf;
  assign inFirstHalf = (extClk == FIRST_HALF_LEVEL);

  // falling request gated by phase
  phase_hold_gate #(.GATE_RISE(1'b0)) reqGate (
    .clk(clk), .rstN(rstN), .phaseOk(inFirstHalf),
    .din(extEnable), .dout(reqGated)
  );

  // rising acknowledge gated by phase
  phase_hold_gate #(.GATE_RISE(1'b1)) doneGate (
    .clk(clk), .rstN(rstN), .phaseOk(inFirstHalf),
    .din(strobes.ackLevel), .dout(doneGated)
  );

  assert_req_follows_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    extEnable |=> reqGated);

  assert_done_phase_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneGated) |-> ($past(extClk) == FIRST_HALF_LEVEL) && $past(strobes.ackLevel));

  assert_req_fall_phase_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqGated) |-> ($past(extClk) == FIRST_HALF_LEVEL) && !$past(extEnable));

  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ackLevel |=> !doneGated);
endmodule

// File: rtl/port_control.sv
module port_control
  import port_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         portEnable,
  input  logic         reqIn,
  input  logic         pauseGrant,
  output portStrobes_t strobes
);
  portState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (portEnable && reqIn) stateNext = ST_PAUSE;
      ST_PAUSE:   if (pauseGrant)          stateNext = ST_XFER;
      ST_XFER:    if (!reqIn)              stateNext = ST_RELEASE;
      ST_RELEASE: if (!pauseGrant)         stateNext = ST_IDLE;
      default:                             stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.pauseReq = (state == ST_PAUSE) || (state == ST_XFER);
    strobes.ackLevel = (state == ST_XFER);
  end

  assert_pause_needs_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.pauseReq) |-> $past(portEnable) && $past(reqIn));

  assert_ack_after_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.ackLevel) |-> $past(pauseGrant) && $past(strobes.pauseReq));

  assert_pause_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pauseReq && reqIn) |=> strobes.pauseReq);

  assert_release_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.pauseReq) |-> !$past(pauseGrant));
endmodule

// File: rtl/sync_edge_port.sv
module sync_edge_port
  import port_pkg::*;
#(
  parameter bit FIRST_HALF_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic extClk,
  input  logic extEnable,
  output logic extDone,
  input  logic portEnable,
  output logic islandReq,
  output logic islandAck,
  output logic pauseReq,
  input  logic pauseGrant
);
  portStrobes_t strobes;
  logic reqGated;
  logic doneGated;

  port_control ctrl (
    .clk(clk), .rstN(rstN), .portEnable(portEnable),
    .reqIn(reqGated), .pauseGrant(pauseGrant), .strobes(strobes)
  );

  port_datapath #(.FIRST_HALF_LEVEL(FIRST_HALF_LEVEL)) dpath (
    .clk(clk), .rstN(rstN), .extClk(extClk), .extEnable(extEnable),
    .strobes(strobes), .reqGated(reqGated), .doneGated(doneGated)
  );

  assign extDone   = doneGated;
  assign islandReq = reqGated;
  assign islandAck = strobes.ackLevel;
  assign pauseReq  = strobes.pauseReq;
endmodule

// File: tb/tb_sync_edge_port.sv
module tb_sync_edge_port;
  localparam int HALF = 4;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extClk = 1'b0;
  logic extEnable = 1'b0;
  logic portEnable = 1'b0;
  logic pauseGrant = 1'b0;
  logic extDone, islandReq, islandAck, pauseReq;

  sync_edge_port dut (
    .clk(clk), .rstN(rstN), .extClk(extClk), .extEnable(extEnable),
    .extDone(extDone), .portEnable(portEnable), .islandReq(islandReq),
    .islandAck(islandAck), .pauseReq(pauseReq), .pauseGrant(pauseGrant)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  int expQ[$];
  int reqQ[$];
  int activeId = -1;
  int doneCount = 0;
  int cycleCnt = 0;

  // knobs written at posedge by the sequence, applied by the env at negedge
  bit portEnWanted = 1'b0;
  bit dropLate = 1'b0;
  int grantDelay = 1;
  int releaseDelay = 1;

  bit sawDeferred = 0, sawReqHeld = 0, sawBlock = 0, deferPending = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // driver: one transfer into both queues
  task automatic pushTransfer(input int id);
    expQ.push_back(id);
    reqQ.push_back(id);
  endtask

  // environment + monitor at negedge
  bit pReq = 0, pAck = 0, pPause = 0, pDone = 0;
  int phaseCnt = 0, hiCnt = 0, loCnt = 0;
  bit dropArmed = 0;

  always @(negedge clk) begin
    bit sReq, sAck, sPause, sDone, eClk, eEn, ePortEn, eGrant;
    int got;
    sReq = islandReq; sAck = islandAck; sPause = pauseReq; sDone = extDone;
    eClk = extClk; eEn = extEnable; ePortEn = portEnable; eGrant = pauseGrant;
    cycleCnt++;
    if (cycleCnt > WATCHDOG) begin
      check(1'b0, "watchdog", cycleCnt, WATCHDOG);
      finishRun();
    end

    if (rstN) begin
      if (eEn) check(sReq, "R2 request follows enable", sReq, 1);
      if (pReq && !sReq) check(eClk && !eEn, "R6 request fell outside first half", eClk, 1);
      if (pReq && !eEn && !eClk) begin
        check(sReq, "R6 falling enable held in low half", sReq, 1);
        sawReqHeld = 1;
      end
      if (!pPause && sPause) begin
        check(ePortEn && pReq, "R3 pause without enable and request", ePortEn, 1);
        check(!eGrant, "R9 pause restarted during release", eGrant, 0);
      end
      if (!pPause && !pAck && pReq && ePortEn && eGrant) begin
        check(!sPause, "R9 new request taken while grant high", sPause, 0);
        sawBlock = 1;
      end
      if (!pAck && sAck) check(eGrant && pPause, "R4 ack before grant", eGrant, 1);
      if (pPause && pReq) check(sPause, "R7 pause dropped with request high", sPause, 1);
      if (pAck && !pReq) check(!sPause && !sAck, "R7 release after request fall", sPause, 0);
      if (pAck && !eClk && !pDone) begin
        check(!sDone, "R5 done passed in low half", sDone, 0);
        deferPending = 1;
      end
      if (pAck && eClk && !pDone) check(sDone, "R5 done in first half", sDone, 1);
      if (!pDone && sDone) begin
        check(eClk && pAck, "R5 done rise conditions", eClk, 1);
        if (deferPending) sawDeferred = 1;
        deferPending = 0;
        if (expQ.size() == 0) check(1'b0, "R5 scoreboard unexpected done", doneCount, -1);
        else begin
          got = expQ.pop_front();
          check(got == activeId, "R5 scoreboard order", activeId, got);
        end
        doneCount++;
      end
      if (pDone && !pAck) check(!sDone, "R8 done clears", sDone, 0);
    end
    pReq = sReq; pAck = sAck; pPause = sPause; pDone = sDone;

    // master clock and master side
    phaseCnt++;
    if (phaseCnt == HALF) begin
      phaseCnt = 0;
      extClk = !extClk;
      if (extClk) begin
        if (extEnable && sDone) begin
          if (dropLate) dropArmed = 1;
          else extEnable = 1'b0;
        end else if (!extEnable && !sDone && reqQ.size() > 0 && rstN) begin
          activeId = reqQ.pop_front();
          extEnable = 1'b1;
        end
      end else if (dropArmed) begin
        extEnable = 1'b0;
        dropArmed = 0;
      end
    end

    // clock generator model
    if (sPause) begin
      loCnt = 0; hiCnt++;
      if (hiCnt >= grantDelay) pauseGrant = 1'b1;
    end else begin
      hiCnt = 0; loCnt++;
      if (loCnt >= releaseDelay) pauseGrant = 1'b0;
    end
    portEnable = portEnWanted;
  end

  task automatic waitDone(input int target);
    while (doneCount < target) @(posedge clk);
  endtask

  initial begin
    int id = 0;
    repeat (3) @(negedge clk);
    check(!islandReq && !islandAck && !pauseReq && !extDone, "R1 reset state", islandReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!islandReq && !islandAck && !pauseReq && !extDone, "R1 after reset", pauseReq, 0);

    // sweep pause latency so ack lands in both halves
    @(posedge clk);
    portEnWanted = 1;
    for (int d = 1; d <= 6; d++) begin
      @(posedge clk);
      grantDelay = d;
      pushTransfer(id); id++;
      waitDone(id);
    end

    // master drops enable on its falling edge
    @(posedge clk);
    dropLate = 1;
    grantDelay = 2; pushTransfer(id); id++; waitDone(id);
    grantDelay = 5; pushTransfer(id); id++; waitDone(id);
    dropLate = 0;

    // port disabled: request must wait
    repeat (20) @(posedge clk);
    portEnWanted = 0;
    grantDelay = 3;
    pushTransfer(id); id++;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(islandReq, "R3 request visible while disabled", islandReq, 1);
    check(!pauseReq, "R3 no pause while disabled", pauseReq, 0);
    check(!extDone, "R3 no done while disabled", extDone, 0);
    @(posedge clk);
    portEnWanted = 1;
    waitDone(id);

    // burst with slow release
    @(posedge clk);
    releaseDelay = 12;
    grantDelay = 2;
    for (int k = 0; k < 4; k++) begin
      pushTransfer(id); id++;
    end
    waitDone(id);
    repeat (40) @(posedge clk);

    @(negedge clk);
    check(sawDeferred, "R5 deferred done observed", sawDeferred, 1);
    check(sawReqHeld, "R6 held request observed", sawReqHeld, 1);
    check(sawBlock, "R9 release blocking observed", sawBlock, 1);
    check(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    check(doneCount == id, "R5 transfer count", doneCount, id);
    finishRun();
  end
endmodule